// File: doc/BRIEF.md
# Power-Domain Event Interrupt Aggregator

This block collects seven level-type event lines from a power-management domain and merges them into one level interrupt for a parent controller. Each line has a pending flag in an event register and an enable flag in an enable register. Both are reached through a simple synchronous register port with an address, a write strobe, write data and combinational read data.

The pending flags are plain read/write storage, not write-one-to-clear. A write loads the written value into every pending flag, so software clears a serviced event by reading the register, dropping the serviced bit and writing the result back. A line that is still asserted keeps its flag set against a written 0. An event that lands between the read and the write-back is lost if the written value holds 0 for it. The block does not guard against this.

Top module: `pwr_evt_irq_agg`

## Requirements
- R1: The pending register sits at byte offset 0x00 and the enable register at byte offset 0x04. Event line i maps to bit i (i = 0..6) of both registers.
- R2: While reset is high at a rising edge, both registers clear to 0. From the next edge on, the interrupt output is low until a flag is pending and enabled.
- R3: An event line that is high at a rising edge sets its pending bit at that edge. A write of 0 to that bit in the same cycle leaves it set.
- R4: A pending bit whose line is low is cleared by a write of 0 to offset 0x00.
- R5: A write of 1 to a pending bit sets it, whatever the line level.
- R6: The interrupt output is high exactly when some bit is set in both registers. A pending bit still latches while its enable bit is 0.
- R7: Bits 31..7 of both registers read as 0 and ignore writes. A read of any other offset returns 0, and a write there changes neither register.
- R8: An event that sets its bit after software has read the pending register is cleared by a write-back that holds 0 for that bit.
- R9: With its line low and no write to offset 0x00, a pending bit holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_lvl | input | 7 | Event lines, level type, already synchronous to clk |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | 1 | Combined interrupt level |

## Verification
Register writes and event levels take effect at the rising edge where they are sampled. Both the read data and the interrupt output reflect the new state as soon as that edge has passed, with no further delay. The bench therefore changes inputs on the falling edge. It samples 1 ns after the next rising edge, and it sets the read address and samples read data within that same settled window. The lost-event case is built cycle by cycle: a read, then a one-cycle event pulse, then the write-back.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;

    localparam int EVT_N   = 7;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;

    localparam int PEND_OFS = 'h00;
    localparam int ENAB_OFS = 'h04;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PEND = 2'd1,
        SEL_ENAB = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic pend_wr;
        logic enab_wr;
    } wr_ctl_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        if (a == ADDR_W'(PEND_OFS))      return SEL_PEND;
        else if (a == ADDR_W'(ENAB_OFS)) return SEL_ENAB;
        else                             return SEL_NONE;
    endfunction

    function automatic wr_ctl_t make_wr_ctl(input reg_sel_e s, input logic we);
        wr_ctl_t c;
        c.pend_wr = we && (s == SEL_PEND);
        c.enab_wr = we && (s == SEL_ENAB);
        return c;
    endfunction

endpackage

// File: rtl/evt_pend_cell.sv
module evt_pend_cell (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic wr_en,
    input  logic wr_val,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (lvl)
            q <= 1'b1;
        else if (wr_en)
            q <= wr_val;
    end

    // R3: an active line always leaves the flag set
    p_line_sets_r3: assert property (@(posedge clk) disable iff (rst)
        lvl |=> q);
    // R4: write of 0 with line low clears
    p_zero_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (!lvl && wr_en && !wr_val) |=> !q);
    // R5: write of 1 sets
    p_one_sets_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_val) |=> q);
    // R9: idle flag holds
    p_idle_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (!lvl && !wr_en) |=> $stable(q));
endmodule

// File: rtl/evt_enab_reg.sv
module evt_enab_reg #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [N-1:0] wr_val,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en)
            q <= wr_val;
    end

    // R1: enable register loads the low bits of the written word
    p_enab_load_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q == $past(wr_val)));
    p_enab_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/evt_read_mux.sv
module evt_read_mux
    import pwr_evt_pkg::*;
#(
    parameter int N  = 7,
    parameter int DW = 32
) (
    input  reg_sel_e      sel,
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  enab,
    output logic [DW-1:0] rdata
);
    localparam int PAD_W = DW - N;

    always_comb begin
        unique case (sel)
            SEL_PEND: rdata = {{PAD_W{1'b0}}, pend};
            SEL_ENAB: rdata = {{PAD_W{1'b0}}, enab};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwr_evt_irq_agg.sv
module pwr_evt_irq_agg
    import pwr_evt_pkg::*;
#(
    parameter int N  = EVT_N,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  evt_lvl,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_we,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_out
);
    reg_sel_e     sel;
    wr_ctl_t      wctl;
    logic [N-1:0] pend_q;
    logic [N-1:0] enab_q;
    logic         unused_wdata_hi;

    assign sel  = decode_ofs(ADDR_W'(reg_addr));
    assign wctl = make_wr_ctl(sel, reg_we);
    assign unused_wdata_hi = ^reg_wdata[DW-1:N];

    for (genvar i = 0; i < N; i++) begin : g_pend
        evt_pend_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .lvl    (evt_lvl[i]),
            .wr_en  (wctl.pend_wr),
            .wr_val (reg_wdata[i]),
            .q      (pend_q[i])
        );
    end

    evt_enab_reg #(.N(N)) u_enab (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wctl.enab_wr),
        .wr_val (reg_wdata[N-1:0]),
        .q      (enab_q)
    );

    evt_read_mux #(.N(N), .DW(DW)) u_rmux (
        .sel   (sel),
        .pend  (pend_q),
        .enab  (enab_q),
        .rdata (reg_rdata)
    );

    assign irq_out = |(pend_q & enab_q);

    // R2: output low on the edge after reset
    p_rst_quiet_r2: assert property (@(posedge clk)
        rst |=> !irq_out);
    // R7: writes to other offsets leave the enable bits unchanged
    p_stray_write_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_we && sel == SEL_NONE) |=> $stable(enab_q));
endmodule

// File: tb/tb_pwr_evt_irq_agg.sv
module tb_pwr_evt_irq_agg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  evt = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwr_evt_irq_agg dut (
        .clk(clk), .rst(rst), .evt_lvl(evt), .reg_addr(addr),
        .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata), .irq_out(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse(input logic [6:0] m);
        @(negedge clk);
        evt = m;
        @(posedge clk); #1;
        evt = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        rd(8'h00, d); chk("R2 pending after reset", d, 0);
        rd(8'h04, d); chk("R2 enable after reset", d, 0);
        chk("R2 irq after reset", irq, 0);
    endtask

    task automatic t_masked_latch();
        logic [31:0] d;
        pulse(7'h01);
        rd(8'h00, d); chk("R3 pulse latched bit0", d, 32'h01);
        chk("R6 irq low while disabled", irq, 0);
        wr(8'h04, 32'h01);
        chk("R6 irq high once enabled", irq, 1);
        wr(8'h00, 32'h00);
        rd(8'h00, d); chk("R4 write 0 clears bit0", d, 0);
        chk("R6 irq low after clear", irq, 0);
    endtask

    task automatic t_active_line();
        logic [31:0] d;
        @(negedge clk); evt = 7'h08;
        wr(8'h00, 32'h00);
        rd(8'h00, d); chk("R3 write 0 loses to active line", d, 32'h08);
        @(negedge clk); evt = '0;
        repeat (3) @(posedge clk); #1;
        rd(8'h00, d); chk("R9 flag held after release", d, 32'h08);
        wr(8'h00, 32'h00);
        rd(8'h00, d); chk("R4 clear after release", d, 0);
    endtask

    task automatic t_force();
        logic [31:0] d;
        wr(8'h00, 32'h50);
        rd(8'h00, d); chk("R5 write 1 forces pending", d, 32'h50);
        wr(8'h04, 32'h10);
        chk("R6 forced bit4 raises irq", irq, 1);
        wr(8'h04, 32'h20);
        chk("R6 disabled bits keep irq low", irq, 0);
        wr(8'h00, 32'h00);
        wr(8'h04, 32'h00);
    endtask

    task automatic t_multi();
        logic [31:0] d;
        @(negedge clk); evt = 7'h42;
        @(posedge clk); #1;
        @(negedge clk); evt = '0;
        @(posedge clk); #1;
        rd(8'h00, d); chk("R1 lines 1 and 6 map to bits 1 and 6", d, 32'h42);
        wr(8'h04, 32'h40);
        chk("R1 enable bit6 raises irq", irq, 1);
        wr(8'h04, 32'h01);
        chk("R6 enable bit0 only keeps irq low", irq, 0);
        wr(8'h00, 32'h00);
        wr(8'h04, 32'h00);
    endtask

    task automatic t_width();
        logic [31:0] d;
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R7 pending upper bits read 0", d, 32'h7F);
        wr(8'h04, 32'hFFFF_FF80);
        rd(8'h04, d); chk("R7 enable upper bits ignored", d, 0);
        wr(8'h08, 32'h0000_0000);
        rd(8'h00, d); chk("R7 stray write leaves pending", d, 32'h7F);
        wr(8'h0C, 32'h0000_007F);
        rd(8'h04, d); chk("R7 stray write leaves enable", d, 0);
        rd(8'h08, d); chk("R7 other offset reads 0", d, 0);
        rd(8'h01, d); chk("R7 unaligned offset reads 0", d, 0);
        wr(8'h00, 32'h00);
    endtask

    task automatic t_rmw_loss();
        logic [31:0] snap;
        logic [31:0] d;
        wr(8'h04, 32'h7F);
        wr(8'h00, 32'h01);
        rd(8'h00, snap); chk("R8 snapshot", snap, 32'h01);
        pulse(7'h04);
        rd(8'h00, d); chk("R8 late event latched", d, 32'h05);
        chk("R8 irq high before write-back", irq, 1);
        wr(8'h00, snap & ~32'h01);
        rd(8'h00, d); chk("R8 late event lost by write-back", d, 0);
        chk("R8 irq low after loss", irq, 0);
        wr(8'h04, 32'h00);
    endtask

    initial begin
        t_reset();
        t_masked_latch();
        t_active_line();
        t_force();
        t_multi();
        t_width();
        t_rmw_loss();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nvec++; nbad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule